// File: doc/BRIEF.md
# Dual-Channel Windowed Sample Statistics

This block watches a stream of paired 16-bit readings, one word from each of two sensor channels, arriving on a sampling strobe. It groups the readings into windows of N samples, where N is set at run time. For each channel separately it tracks the smallest value, the largest value and the running sum over the window. After the N-th sample of a window, a sequential divider turns each sum into a truncated average. The six results are then copied to the output registers together, and a one-cycle `done` pulse marks the copy. The next window has already started with the sample that follows.

N is chosen as the window duration times the sampling rate. For example, a 10 ms window sampled at 32 kHz gives N = 320. A controller state machine drives the sequence through four named states:
- `ST_IDLE`: enable is low and nothing is collected.
- `ST_COLLECT`: samples are counted and folded into the per-channel trackers.
- `ST_DIVIDE`: both dividers are busy.
- `ST_PUBLISH`: the results are latched and `done` is raised on the following cycle.

The transitions are:
- IDLE→COLLECT when enable is high.
- COLLECT→DIVIDE (or PUBLISH→DIVIDE) on the edge that accepts a window's last sample.
- DIVIDE→PUBLISH when the dividers are no longer busy.
- PUBLISH→COLLECT unconditionally.
- Any state→IDLE when enable is low.

Samples that arrive during DIVIDE or PUBLISH count toward the next window. Successive strobes must be at least 30 clock cycles apart, so that a window cannot close while the divider is still busy.

Top module: `winstat_top`

## Requirements
- R1: After reset all six result outputs read 0 and `done` is low.
- R2: After a window, `min_a`/`min_b` hold the smallest sample of that window on channel A/B, compared as unsigned 16-bit values.
- R3: After a window, `max_a`/`max_b` hold the largest sample of that window on channel A/B, compared as unsigned 16-bit values.
- R4: After a window, `avg_a`/`avg_b` hold floor(sum of the window's samples / N), computed separately per channel.
- R5: The two channels are independent: results for one channel depend only on that channel's sample words.
- R6: `done` is high for exactly one cycle. It rises 28 rising edges after the edge that accepts the N-th sample (SUM_W+2, with SUM_W = DATA_W+LEN_W = 26). The result outputs take their new values on the same edge.
- R7: The result outputs change only on the edge that raises `done`, and hold their values otherwise.
- R8: A `win_len` value of 0 or 1 is treated as a window of 2 samples.
- R9: While `en` is low, strobes are ignored, no `done` is produced and the outputs hold. Lowering `en` discards a partly filled window, so counting restarts at sample 1 once `en` returns.
- R10: The first sample of every window loads the minimum and maximum directly. Values from the previous window never leak into the new results.
- R11: A 1023-sample window of 0xFFFF on both channels gives average 0xFFFF, with no wrap in the sum.
- R12: `win_len` is sampled at the first sample of a window. A change made mid-window takes effect from the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Statistics enable |
| win_len | input | 10 | Window length N in samples (0/1 act as 2) |
| smp_valid | input | 1 | Sample strobe, one cycle per sample pair |
| smp_a | input | 16 | Channel A sample word |
| smp_b | input | 16 | Channel B sample word |
| min_a | output | 16 | Channel A window minimum |
| max_a | output | 16 | Channel A window maximum |
| avg_a | output | 16 | Channel A window average |
| min_b | output | 16 | Channel B window minimum |
| max_b | output | 16 | Channel B window maximum |
| avg_b | output | 16 | Channel B window average |
| done | output | 1 | One-cycle pulse when new results are latched |

## Verification
Each kind of internal fault shows at the ports within one window:
- A sample counter that is off by one moves the `done` pulse by a whole sample period, and spoils every average.
- A minimum or maximum register not reloaded at a window's first sample leaks the previous window's extremes into the next result.
- A divider that stops early or runs late shows up on the next `done` as a wrong average, or as a pulse that is not 28 edges after the last sample.

Each of these faults is therefore exposed at the first `done` after it, or by the absence of that `done`.

// File: rtl/winstat_pkg.sv
package winstat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DIVIDE  = 2'd2,
        ST_PUBLISH = 2'd3
    } wst_state_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/winstat_ctrl.sv
module winstat_ctrl
    import winstat_pkg::*;
#(
    parameter int LEN_W   = 10,
    parameter int MIN_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LEN_W-1:0] win_len,
    input  logic             smp_valid,
    input  logic             div_busy,
    output logic             acc,
    output logic             first,
    output logic             last,
    output logic             div_start,
    output logic [LEN_W-1:0] div_den,
    output logic             publish,
    output logic             done
);

    localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_LEN);

    wst_state_t       state, state_nxt;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] win_n;
    logic [LEN_W-1:0] len_req;
    logic [LEN_W-1:0] len_eff;

    assign len_req   = (win_len < LEN_FLOOR) ? LEN_FLOOR : win_len;
    assign first     = (cnt == '0);
    assign len_eff   = first ? len_req : win_n;
    assign acc       = smp_valid && en && (state != ST_IDLE);
    assign last      = (cnt == len_eff - 1'b1);
    assign div_start = acc && last;
    assign div_den   = len_eff;
    assign publish   = (state == ST_PUBLISH) && en;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (en) state_nxt = ST_COLLECT;
            ST_COLLECT: if (div_start) state_nxt = ST_DIVIDE;
            ST_DIVIDE:  if (!div_busy) state_nxt = ST_PUBLISH;
            ST_PUBLISH: state_nxt = div_start ? ST_DIVIDE : ST_COLLECT;
            default:    state_nxt = ST_IDLE;
        endcase
        if (!en) state_nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            win_n <= LEN_FLOOR;
            done  <= 1'b0;
        end else begin
            done <= publish;
            if (!en) begin
                cnt <= '0;
            end else if (acc) begin
                cnt <= last ? '0 : cnt + 1'b1;
                if (first) win_n <= len_req;
            end
        end
    end

    // R8: the latched window length never falls below the floor
    a_r8_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        win_n >= LEN_FLOOR);

    // R9: dropping the enable restarts the count
    a_r9_dis_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    // R6: results are published only after a divide phase
    a_r6_pub_after_div: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUBLISH) |-> ($past(state) == ST_DIVIDE));

endmodule

// File: rtl/winstat_chan.sv
module winstat_chan #(
    parameter int DATA_W = 16,
    parameter int SUM_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              first,
    input  logic              last,
    input  logic [DATA_W-1:0] smp,
    output logic [SUM_W-1:0]  nxt_sum,
    output logic [DATA_W-1:0] win_min,
    output logic [DATA_W-1:0] win_max
);

    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] run_min, run_max;
    logic [DATA_W-1:0] nxt_min, nxt_max;

    assign nxt_sum = first ? SUM_W'(smp) : sum + SUM_W'(smp);
    assign nxt_min = (first || smp < run_min) ? smp : run_min;
    assign nxt_max = (first || smp > run_max) ? smp : run_max;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum     <= '0;
            run_min <= '0;
            run_max <= '0;
            win_min <= '0;
            win_max <= '0;
        end else if (acc) begin
            sum     <= nxt_sum;
            run_min <= nxt_min;
            run_max <= nxt_max;
            if (last) begin
                win_min <= nxt_min;
                win_max <= nxt_max;
            end
        end
    end

    // R2/R3: running extremes stay ordered
    a_r2_run_order: assert property (@(posedge clk) disable iff (!rst_n)
        run_min <= run_max);

    // R11: the running sum never wraps inside a window
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !first) |=> (sum >= $past(sum)));

endmodule

// File: rtl/winstat_div.sv
module winstat_div #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic [NUM_W-1:0] quo
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [CNT_W-1:0] steps;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign busy  = (steps != '0);
    assign trial = {rem, quo[NUM_W-1]};
    assign fits  = (trial >= {1'b0, den_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps <= '0;
            rem   <= '0;
            den_q <= '1;
            quo   <= '0;
        end else if (start) begin
            steps <= CNT_W'(NUM_W);
            rem   <= '0;
            den_q <= den;
            quo   <= num;
        end else if (busy) begin
            steps <= steps - 1'b1;
            rem   <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
            quo   <= {quo[NUM_W-2:0], fits};
        end
    end

    // R4: the partial remainder stays below the divisor
    a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem < den_q));

endmodule

// File: rtl/winstat_top.sv
module winstat_top
    import winstat_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LEN_W-1:0]  win_len,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_a,
    input  logic [DATA_W-1:0] smp_b,
    output logic [DATA_W-1:0] min_a,
    output logic [DATA_W-1:0] max_a,
    output logic [DATA_W-1:0] avg_a,
    output logic [DATA_W-1:0] min_b,
    output logic [DATA_W-1:0] max_b,
    output logic [DATA_W-1:0] avg_b,
    output logic              done
);

    localparam int SUM_W = DATA_W + LEN_W;

    logic             acc, first, last, div_start, publish;
    logic [LEN_W-1:0] div_den;
    logic [DATA_W-1:0] smp_arr [NUM_CH];
    logic [DATA_W-1:0] wmin    [NUM_CH];
    logic [DATA_W-1:0] wmax    [NUM_CH];
    logic [SUM_W-1:0]  wsum    [NUM_CH];
    logic [SUM_W-1:0]  wquo    [NUM_CH];
    logic [NUM_CH-1:0] busy_v;
    logic [DATA_W-1:0] r_min   [NUM_CH];
    logic [DATA_W-1:0] r_max   [NUM_CH];
    logic [DATA_W-1:0] r_avg   [NUM_CH];

    assign smp_arr[0] = smp_a;
    assign smp_arr[1] = smp_b;

    winstat_ctrl #(.LEN_W(LEN_W), .MIN_LEN(2)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .win_len   (win_len),
        .smp_valid (smp_valid),
        .div_busy  (|busy_v),
        .acc       (acc),
        .first     (first),
        .last      (last),
        .div_start (div_start),
        .div_den   (div_den),
        .publish   (publish),
        .done      (done)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        winstat_chan #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc     (acc),
            .first   (first),
            .last    (last),
            .smp     (smp_arr[ch]),
            .nxt_sum (wsum[ch]),
            .win_min (wmin[ch]),
            .win_max (wmax[ch])
        );

        winstat_div #(.NUM_W(SUM_W), .DEN_W(LEN_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start),
            .num   (wsum[ch]),
            .den   (div_den),
            .busy  (busy_v[ch]),
            .quo   (wquo[ch])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_min[ch] <= '0;
                r_max[ch] <= '0;
                r_avg[ch] <= '0;
            end else if (publish) begin
                r_min[ch] <= wmin[ch];
                r_max[ch] <= wmax[ch];
                r_avg[ch] <= wquo[ch][DATA_W-1:0];
            end
        end
    end

    assign min_a = r_min[0];
    assign max_a = r_max[0];
    assign avg_a = r_avg[0];
    assign min_b = r_min[1];
    assign max_b = r_max[1];
    assign avg_b = r_avg[1];

    // R6: done is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: results hold between publications
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(min_a) && $stable(max_a) && $stable(avg_a) &&
                   $stable(min_b) && $stable(max_b) && $stable(avg_b)));

    // R4: a published average lies between the published extremes
    a_r4_avg_between: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (min_a <= avg_a && avg_a <= max_a &&
                  min_b <= avg_b && avg_b <= max_b));

endmodule

// File: tb/winstat_top_tb.sv
module winstat_top_tb;

    localparam int DATA_W = 16;
    localparam int LEN_W  = 10;
    localparam int LAT    = DATA_W + LEN_W + 2;
    localparam int GAP    = 36;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [LEN_W-1:0]  win_len = '0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_a = '0, smp_b = '0;
    logic [DATA_W-1:0] min_a, max_a, avg_a, min_b, max_b, avg_b;
    logic              done;

    int n_chk = 0;
    int n_fail = 0;
    int done_seen = 0;

    always #10 clk = ~clk;

    winstat_top #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .win_len(win_len),
        .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .min_a(min_a), .max_a(max_a), .avg_a(avg_a),
        .min_b(min_b), .max_b(max_b), .avg_b(avg_b), .done(done)
    );

    always @(negedge clk) if (done) done_seen++;

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(int mode, int ch, int i);
        int v;
        case (mode)
            0: v = (ch == 0) ? (i * 4099 + 17) : (50000 - i * 731);
            1: v = 65535;
            2: v = (ch == 0) ? ((i == 1) ? 0 : 30000 + i)
                             : ((i == 2) ? 65535 : 20000 - i);
            default: v = (ch == 0) ? (1000 + i) : (2000 - i * 3);
        endcase
        return v & 16'hFFFF;
    endfunction

    task automatic send(int a, int b);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_a = DATA_W'(a);
        smp_b = DATA_W'(b);
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // sends n samples; optionally changes win_len after the first one
    task automatic run_win(int n, int mode, int chg_len, string tag);
        int mn[2], mx[2];
        longint sm[2];
        int j;
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < 2; c++) begin
                int v = gen(mode, c, i);
                if (i == 0) begin mn[c] = v; mx[c] = v; sm[c] = v; end
                else begin
                    if (v < mn[c]) mn[c] = v;
                    if (v > mx[c]) mx[c] = v;
                    sm[c] += v;
                end
            end
            @(negedge clk);
            smp_valid = 1'b1;
            smp_a = DATA_W'(gen(mode, 0, i));
            smp_b = DATA_W'(gen(mode, 1, i));
            @(posedge clk);
            @(negedge clk);
            smp_valid = 1'b0;
            if (i == 0 && chg_len >= 0) win_len = LEN_W'(chg_len);
            if (i < n - 1) begin
                check({tag, " R6 no early done"}, done, 0);
                repeat (GAP) @(negedge clk);
            end
        end
        j = 0;
        while (!done && j < LAT + 20) begin
            @(negedge clk);
            j++;
        end
        check({tag, " R6 latency"}, j, LAT);
        check({tag, " R2 min_a"}, min_a, mn[0]);
        check({tag, " R2 min_b"}, min_b, mn[1]);
        check({tag, " R3 max_a"}, max_a, mx[0]);
        check({tag, " R3 max_b"}, max_b, mx[1]);
        check({tag, " R4 avg_a"}, avg_a, sm[0] / n);
        check({tag, " R4 avg_b"}, avg_b, sm[1] / n);
        @(negedge clk);
        check({tag, " R6 pulse width"}, done, 0);
        repeat (GAP) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 min_a", min_a, 0);
        check("R1 max_b", max_b, 0);
        check("R1 avg_a", avg_a, 0);
        check("R1 avg_b", avg_b, 0);
        check("R1 done", done, 0);
    endtask

    task automatic t_basic();
        win_len = 10'd5;
        run_win(5, 0, -1, "basic R5");
    endtask

    task automatic t_first_load();
        win_len = 10'd4;
        run_win(4, 2, -1, "extremes");
        run_win(4, 3, -1, "R10 reload");
    endtask

    task automatic t_clamp();
        win_len = 10'd0;
        run_win(2, 0, -1, "R8 len0");
        win_len = 10'd1;
        run_win(2, 3, -1, "R8 len1");
    endtask

    task automatic t_len_change();
        win_len = 10'd3;
        run_win(3, 0, 6, "R12 old len");
        run_win(6, 3, -1, "R12 new len");
    endtask

    task automatic t_enable();
        int seen0;
        logic [DATA_W-1:0] hold_a, hold_b;
        win_len = 10'd3;
        send(7, 8);
        repeat (GAP) @(negedge clk);
        send(9, 10);
        repeat (GAP) @(negedge clk);
        en = 1'b0;
        hold_a = avg_a;
        hold_b = min_b;
        seen0 = done_seen;
        for (int i = 0; i < 4; i++) begin
            send(60000, 1);
            repeat (GAP) @(negedge clk);
        end
        check("R9 no done while disabled", done_seen - seen0, 0);
        check("R9 avg_a held", avg_a, hold_a);
        check("R9 min_b held", min_b, hold_b);
        en = 1'b1;
        repeat (5) @(negedge clk);
        run_win(3, 3, -1, "R9 restart");
    endtask

    task automatic t_overflow();
        win_len = 10'd1023;
        run_win(1023, 1, -1, "R11 full");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        en = 1'b1;
        repeat (4) @(negedge clk);
        t_basic();
        t_first_load();
        t_clamp();
        t_len_change();
        t_enable();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule